// File: doc/BRIEF.md
# Content-Addressable Match Memory

A small associative store kept in flip-flops. Software-style traffic can write a word at an address and read a word back from an address, as with any RAM. It can also present a search key: in one cycle, every stored word is compared with that key. The block returns a vector with one flag per address and a single miss flag that is high only when no flag is set.

Each location carries a valid bit. Reset clears all valid bits, and any write sets the valid bit of its location. A location that has never been written can never report a hit, even when its cleared contents equal the key. At most one operation takes effect per clock. The priority order is write, then match, then read. Every result is registered and appears one clock after its request. The comparator can be built as a direct equality or as a reduced XOR of the two words; a parameter selects which. The word width, the depth and the address width are parameters.

Top module: `cam_match_mem`

## Requirements
- R1: A cycle with `wr_en` high stores `wr_data` at location `addr` and marks that location valid. From the next clock on, a read of `addr` returns the new value.
- R2: A cycle with `rd_en` high, and with both `wr_en` and `match_req` low, loads `rd_data` at the next clock with the word at `addr`. In any other cycle, `rd_data` keeps its value.
- R3: A cycle with `match_req` high and `wr_en` low updates `hit_vec` at the next clock. Bit i of `hit_vec` is 1 exactly when location i is valid and holds a word equal to `key`. Several bits may be set at once.
- R4: `miss` is updated together with `hit_vec`. It is 1 exactly when no bit of the new `hit_vec` is set.
- R5: A location that is not valid never sets its `hit_vec` bit, whatever it contains.
- R6: When `wr_en` and `match_req` are high in the same cycle, the write is performed. `hit_vec` and `miss` keep their previous values.
- R7: When `match_req` and `rd_en` are high in the same cycle, with `wr_en` low, the match is performed. The read is ignored and `rd_data` keeps its value.
- R8: While `rst_n` is low, every word is cleared to 0 and marked invalid. `rd_data` is 0, `hit_vec` is 0 and `miss` is 1.
- R9: In a cycle without an accepted match, `hit_vec` and `miss` keep their values, even when a write changes the stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request for location `addr` |
| rd_en | input | 1 | Read request for location `addr` |
| match_req | input | 1 | Compare `key` against all locations |
| addr | input | 3 | Location for read or write |
| wr_data | input | 8 | Data to store |
| key | input | 8 | Search key |
| rd_data | output | 8 | Registered read result |
| hit_vec | output | 8 | Registered per-location match flags, bit i for location i |
| miss | output | 1 | Registered flag, 1 when no location matched |

## Verification
The bench builds the block with its default values: eight locations of eight bits, using the equality comparator. At this size, every one of the 256 key values can be searched against a half-filled store and then against a full store. The bench also covers a store that holds a duplicate word, so it reaches every combination of valid and invalid locations with equal and unequal contents. With only eight locations, every address can be read and written directly. This leaves room to exercise all pairings of simultaneous requests, checking the priority order and the hold behaviour of each output.

// File: rtl/cam_pkg.sv
package cam_pkg;

   typedef enum logic [1:0] {
      CAM_IDLE  = 2'd0,
      CAM_WRITE = 2'd1,
      CAM_MATCH = 2'd2,
      CAM_READ  = 2'd3
   } cam_op_e;

   // Arbitration: write wins over match, match wins over read.
   function automatic cam_op_e cam_pick_op(input logic wr, input logic mt, input logic rd);
      cam_op_e op;
      if (wr)      op = CAM_WRITE;
      else if (mt) op = CAM_MATCH;
      else if (rd) op = CAM_READ;
      else         op = CAM_IDLE;
      return op;
   endfunction

endpackage

// File: rtl/cam_store.sv
module cam_store #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic                        re,
   input  logic [AW-1:0]               loc,
   input  logic [WIDTH-1:0]            wdata,
   output logic [DEPTH-1:0][WIDTH-1:0] words,
   output logic [DEPTH-1:0]            valid,
   output logic [WIDTH-1:0]            rdata
);

   localparam int SLOTS = 1 << AW;

   generate
      if (DEPTH < 2)     begin : g_bad_depth $error("cam_store: DEPTH must be at least 2"); end
      if (SLOTS < DEPTH) begin : g_bad_aw    $error("cam_store: AW too narrow for DEPTH"); end
      if (WIDTH < 1)     begin : g_bad_width $error("cam_store: WIDTH must be positive"); end
   endgenerate

   logic [WIDTH-1:0] rd_pick;

   always_comb begin
      rd_pick = '0;
      for (int i = 0; i < DEPTH; i++)
         if (loc == AW'(i)) rd_pick = words[i];
   end

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               words[g] <= '0;
               valid[g] <= 1'b0;
            end else if (we && loc == AW'(g)) begin
               words[g] <= wdata;
               valid[g] <= 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= rd_pick;
   end

   assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (words[$past(loc)] == $past(wdata)) && valid[$past(loc)]);

   assert_read_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rdata));

endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8,
   parameter int STYLE = 0
) (
   input  logic [DEPTH-1:0][WIDTH-1:0] words,
   input  logic [DEPTH-1:0]            valid,
   input  logic [WIDTH-1:0]            key,
   output logic [DEPTH-1:0]            eq_vec
);

   generate
      if (STYLE != 0 && STYLE != 1) begin : g_bad_style
         $error("cam_compare: STYLE must be 0 or 1");
      end
   endgenerate

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_cmp
         if (STYLE == 0) begin : g_eq
            assign eq_vec[g] = valid[g] && (words[g] == key);
         end else begin : g_xor
            logic [WIDTH-1:0] diff;
            assign diff      = words[g] ^ key;
            assign eq_vec[g] = valid[g] & ~(|diff);
         end
      end
   endgenerate

endmodule

// File: rtl/cam_result.sv
module cam_result #(
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [DEPTH-1:0] eq_vec,
   output logic [DEPTH-1:0] hit_q,
   output logic             miss_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q  <= '0;
         miss_q <= 1'b1;
      end else if (capture) begin
         hit_q  <= eq_vec;
         miss_q <= ~(|eq_vec);
      end
   end

   assert_miss_nor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      miss_q == (hit_q == '0));

   assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(hit_q) && $stable(miss_q));

endmodule

// File: rtl/cam_match_mem.sv
module cam_match_mem #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8,
   parameter int AW    = $clog2(DEPTH),
   parameter int STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             match_req,
   input  logic [AW-1:0]    addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [WIDTH-1:0] key,
   output logic [WIDTH-1:0] rd_data,
   output logic [DEPTH-1:0] hit_vec,
   output logic             miss
);

   import cam_pkg::*;

   cam_op_e                     op;
   logic [DEPTH-1:0][WIDTH-1:0] words;
   logic [DEPTH-1:0]            valid;
   logic [DEPTH-1:0]            eq_vec;

   assign op = cam_pick_op(wr_en, match_req, rd_en);

   cam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (op == CAM_WRITE),
      .re    (op == CAM_READ),
      .loc   (addr),
      .wdata (wr_data),
      .words (words),
      .valid (valid),
      .rdata (rd_data)
   );

   cam_compare #(.DEPTH(DEPTH), .WIDTH(WIDTH), .STYLE(STYLE)) u_cmp (
      .words  (words),
      .valid  (valid),
      .key    (key),
      .eq_vec (eq_vec)
   );

   cam_result #(.DEPTH(DEPTH)) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (op == CAM_MATCH),
      .eq_vec  (eq_vec),
      .hit_q   (hit_vec),
      .miss_q  (miss)
   );

   assert_invalid_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec & ~valid) == '0);

   assert_write_beats_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && match_req |=> $stable(hit_vec) && $stable(miss));

   assert_match_beats_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      match_req && rd_en |=> $stable(rd_data));

   assert_match_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
      match_req && !wr_en |=> hit_vec == $past(eq_vec));

endmodule

// File: tb/cam_match_mem_test.sv
module cam_match_mem_test;

   localparam int D = 8;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0, rd_en = 1'b0, match_req = 1'b0;
   logic [2:0]   addr = '0;
   logic [W-1:0] wr_data = '0, key = '0;
   logic [W-1:0] rd_data;
   logic [D-1:0] hit_vec;
   logic         miss;

   int checks = 0;
   int fails  = 0;

   logic [W-1:0] m_word [D];
   logic         m_val  [D];
   logic [W-1:0] e_rd;
   logic [D-1:0] e_hit;
   logic         e_miss;

   always #5 clk = ~clk;

   cam_match_mem uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .match_req(match_req),
      .addr(addr), .wr_data(wr_data), .key(key),
      .rd_data(rd_data), .hit_vec(hit_vec), .miss(miss)
   );

   task automatic check_all(input string tag);
      checks++;
      if (rd_data !== e_rd) begin
         fails++;
         $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, e_rd);
      end
      checks++;
      if (hit_vec !== e_hit) begin
         fails++;
         $display("FAIL %s hit_vec actual %b expected %b", tag, hit_vec, e_hit);
      end
      checks++;
      if (miss !== e_miss) begin
         fails++;
         $display("FAIL %s miss actual %b expected %b", tag, miss, e_miss);
      end
   endtask

   // Apply one request cycle, update the model by priority, then check.
   task automatic op(input logic w, input logic r, input logic m,
                     input logic [2:0] a, input logic [W-1:0] d,
                     input logic [W-1:0] k, input string tag);
      @(negedge clk);
      wr_en = w; rd_en = r; match_req = m; addr = a; wr_data = d; key = k;
      @(negedge clk);
      wr_en = 0; rd_en = 0; match_req = 0;
      if (w) begin
         m_word[a] = d;
         m_val[a]  = 1'b1;
      end else if (m) begin
         for (int i = 0; i < D; i++) e_hit[i] = m_val[i] && (m_word[i] == k);
         e_miss = (e_hit == '0);
      end else if (r) begin
         e_rd = m_word[a];
      end
      check_all(tag);
   endtask

   function automatic logic [W-1:0] pat(input int i);
      return W'((i * 37 + 5) & 255);
   endfunction

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < D; i++) begin m_word[i] = '0; m_val[i] = 1'b0; end
      e_rd = '0; e_hit = '0; e_miss = 1'b1;
      repeat (3) @(negedge clk);
      check_all("R8 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R8 after reset");

      // R5/R8: empty store holds zeros but nothing may match, key 0 included
      op(0, 0, 1, 0, 0, 8'h00, "R5 empty key 0");
      op(0, 0, 1, 0, 0, 8'h5a, "R5 empty key 5a");
      for (int i = 0; i < D; i++) op(0, 1, 0, 3'(i), 0, 0, "R8 read cleared word");

      // R1: fill half the store
      for (int i = 0; i < D / 2; i++) op(1, 0, 0, 3'(i), pat(i), 0, "R1 write");
      for (int k = 0; k < 256; k++) op(0, 0, 1, 0, 0, W'(k), "R3 R4 R5 half sweep");

      // R9: write that would change matching, flags must hold
      op(0, 0, 1, 0, 0, pat(0), "R3 match word0");
      op(1, 0, 0, 3'd0, 8'hee, 0, "R9 write after match");
      op(0, 1, 0, 3'd0, 0, 0, "R1 R2 read back");

      // fill everything
      for (int i = 0; i < D; i++) op(1, 0, 0, 3'(i), pat(i), 0, "R1 write full");
      for (int i = 0; i < D; i++) op(0, 1, 0, 3'(i), 0, 0, "R2 read full");
      for (int k = 0; k < 256; k++) op(0, 0, 1, 0, 0, W'(k), "R3 R4 full sweep");

      // duplicate word: two flags at once
      op(1, 0, 0, 3'd5, pat(2), 0, "R1 write duplicate");
      op(0, 0, 1, 0, 0, pat(2), "R3 duplicate match");
      op(0, 0, 1, 0, 0, pat(5), "R4 overwritten value misses");

      // R6: write and match together
      op(0, 0, 1, 0, 0, pat(7), "R3 set flags");
      op(1, 0, 1, 3'd6, pat(7), pat(7), "R6 write beats match");
      op(0, 1, 0, 3'd6, 0, 0, "R6 write happened");
      op(0, 0, 1, 0, 0, pat(7), "R3 two flags after R6 write");

      // R7: match and read together
      op(0, 1, 0, 3'd1, 0, 0, "R2 read loc1");
      op(0, 1, 1, 3'd3, 0, 8'h01, "R7 match beats read");
      op(1, 1, 0, 3'd4, 8'h77, 0, "R2 write beats read");
      op(1, 1, 1, 3'd2, 8'h99, 8'h77, "R6 R7 all three");
      op(0, 1, 0, 3'd4, 0, 0, "R1 read loc4");
      op(0, 1, 0, 3'd2, 0, 0, "R1 read loc2");
      op(0, 0, 0, 3'd2, 0, 0, "R9 idle holds");

      // R8 again: reset mid-run clears valid bits
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < D; i++) begin m_word[i] = '0; m_val[i] = 1'b0; end
      e_rd = '0; e_hit = '0; e_miss = 1'b1;
      check_all("R8 second reset");
      op(0, 0, 1, 0, 0, pat(3), "R5 miss after reset");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule